// File: doc/BRIEF.md
# D-PHY Test-Port Register Write Sequencer

This block takes a request to write one byte into one register of a D-PHY's test/configuration port and plays it out as a timed sequence on the port's pins. The pins are a test clock, a test enable, a test clear and a shared data-in bus. The request interface is a valid/ready stream carrying an address and a data byte. The PHY takes the address on the bus at a falling test-clock edge while enable is high. It takes the data byte at the next rising edge while enable is low.

Each write is split into five pin phases. Every phase holds its pin levels for a programmable number of system clocks, so that slow setup and hold windows on the PHY side are met. At the end of a write the block raises `done` for one cycle. The pins then rest in the state that the next write opens with.

Back-pressure rules: `req_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold address, data and hold count stable while `req_valid` is high and `req_ready` is low. A request withdrawn before `req_ready` rises is never written.

Top module: `phy_cfg_writer`

## Requirements
- R1: While reset is held, and whenever idle, the pins rest at test clock high, test enable low, test clear low and bus 0x00, with `busy` low, `req_ready` high and `done` low.
- R2: A request is accepted only on a clock where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as `busy` is high, and a request offered during a write and withdrawn before it ends produces no PHY write.
- R3: After acceptance the pins step through five phases in this order: (0) clock high, enable low, bus 0x00; (1) clock high, enable high, bus = address; (2) clock low, enable high, bus = address; (3) clock low, enable low, bus = data; (4) clock high, enable low, bus = data.
- R4: The only falling test-clock edge of a write happens with enable high and the address stable on the bus. The only rising edge happens with enable low and the data stable on the bus. A PHY that latches on those edges records exactly the requested (address, data) pair.
- R5: Each phase lasts H system clocks, where H is `hold_cycles` and the value 0 counts as 1. `busy` is high for exactly 5·H cycles, starting in the cycle after the accepting edge.
- R6: The hold count is captured when the request is accepted. Changing `hold_cycles` during a write does not change the length of that write.
- R7: The test clear pin stays low throughout every write.
- R8: `done` is high for exactly one cycle, the first cycle after phase 4 ends. In that cycle `busy` is low and `req_ready` is high, so a waiting request is accepted back-to-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 8 | PHY register address to write |
| req_data | input | 8 | Byte to program into that register |
| hold_cycles | input | 8 | System clocks per pin phase (0 treated as 1) |
| busy | output | 1 | A write is being played out |
| done | output | 1 | One-cycle pulse at the end of a write |
| ptest_clk | output | 1 | Test clock pin |
| ptest_en | output | 1 | Test enable pin |
| ptest_clr | output | 1 | Test clear pin (held inactive) |
| ptest_din | output | 8 | Shared address/data bus to the PHY |

## Verification
Writes are driven with hold counts of 1, 3, 0 and 5, so phase length, the zero-as-one rule and the 5·H busy window are each exercised separately. The address/data pairs are 0x00/0xFF, 0xA5/0x5A, 0xFF/0x00 and two writes to one address with different data, so a swapped, stale or mis-latched bus value shows in the PHY model's record. One write has a foreign request pulsed mid-write to show it is not taken. Another changes the hold input mid-write to show the length was captured at acceptance. The last two writes are offered back-to-back to show acceptance in the `done` cycle.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_CLK_HI   = 3'd1,
    PH_EN_ADDR  = 3'd2,
    PH_CLK_LO   = 3'd3,
    PH_EN_DATA  = 3'd4,
    PH_CLK_RISE = 3'd5
  } phase_e;

  function automatic phase_e phase_after(phase_e cur);
    case (cur)
      PH_CLK_HI:   phase_after = PH_EN_ADDR;
      PH_EN_ADDR:  phase_after = PH_CLK_LO;
      PH_CLK_LO:   phase_after = PH_EN_DATA;
      PH_EN_DATA:  phase_after = PH_CLK_RISE;
      default:     phase_after = PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/cfgw_phase_timer.sv
module cfgw_phase_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOLD_W-1:0] length,
  output logic              expired
);
  logic [HOLD_W-1:0] remain_q;

  // length is always at least 1; the counter holds length-1 down to 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (load)             remain_q <= length - HOLD_W'(1);
    else if (remain_q != '0)   remain_q <= remain_q - HOLD_W'(1);
  end

  assign expired = (remain_q == '0);
endmodule

// File: rtl/cfgw_seq_fsm.sv
module cfgw_seq_fsm
  import cfgw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  logic   expired,
  output phase_e phase,
  output logic   advance,
  output logic   done
);
  phase_e phase_q;

  assign advance = (phase_q != PH_IDLE) && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        phase_q <= PH_CLK_HI;
      end else if (advance) begin
        phase_q <= phase_after(phase_q);
        if (phase_q == PH_CLK_RISE) done <= 1'b1;
      end
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/cfgw_pin_drive.sv
module cfgw_pin_drive
  import cfgw_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  phase_e           phase,
  input  logic [BUS_W-1:0] addr,
  input  logic [BUS_W-1:0] data,
  output logic             tclk,
  output logic             ten,
  output logic             tclr,
  output logic [BUS_W-1:0] tdin
);
  always_comb begin
    tclk = 1'b1;
    ten  = 1'b0;
    tdin = '0;
    case (phase)
      PH_EN_ADDR:  begin ten = 1'b1; tdin = addr; end
      PH_CLK_LO:   begin tclk = 1'b0; ten = 1'b1; tdin = addr; end
      PH_EN_DATA:  begin tclk = 1'b0; tdin = data; end
      PH_CLK_RISE: begin tdin = data; end
      default:     ;
    endcase
  end

  assign tclr = 1'b0;
endmodule

// File: rtl/phy_cfg_writer.sv
module phy_cfg_writer
  import cfgw_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_addr,
  input  logic [BUS_W-1:0]  req_data,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              busy,
  output logic              done,
  output logic              ptest_clk,
  output logic              ptest_en,
  output logic              ptest_clr,
  output logic [BUS_W-1:0]  ptest_din
);
  localparam logic [HOLD_W-1:0] MIN_HOLD = HOLD_W'(1);

  phase_e            phase;
  logic              accept, advance, expired, timer_load;
  logic [BUS_W-1:0]  addr_q, data_q;
  logic [HOLD_W-1:0] hold_in, hold_q;

  assign req_ready = (phase == PH_IDLE);
  assign busy      = ~req_ready;
  assign accept    = req_valid & req_ready;
  assign hold_in   = (hold_cycles == '0) ? MIN_HOLD : hold_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      hold_q <= MIN_HOLD;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
      hold_q <= hold_in;
    end
  end

  assign timer_load = accept | (advance & (phase != PH_CLK_RISE));

  cfgw_phase_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .length  (accept ? hold_in : hold_q),
    .expired (expired)
  );

  cfgw_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .expired (expired),
    .phase   (phase),
    .advance (advance),
    .done    (done)
  );

  cfgw_pin_drive #(.BUS_W(BUS_W)) u_pins (
    .phase (phase),
    .addr  (addr_q),
    .data  (data_q),
    .tclk  (ptest_clk),
    .ten   (ptest_en),
    .tclr  (ptest_clr),
    .tdin  (ptest_din)
  );
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic             ptest_clk,
  input logic             ptest_en,
  input logic [BUS_W-1:0] ptest_din
);
  // R2
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R1
  idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ptest_clk && !ptest_en));

  // R3
  en_rise_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptest_en) |-> ptest_clk);

  // R4
  addr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ptest_clk) |-> (ptest_en && $stable(ptest_din)));

  // R4
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptest_clk) |-> (!ptest_en && $stable(ptest_din)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind phy_cfg_writer cfgw_checker #(.BUS_W(BUS_W)) u_cfgw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .ptest_clk (ptest_clk),
  .ptest_en  (ptest_en),
  .ptest_din (ptest_din)
);

// File: tb/phy_cfg_writer_test.sv
module phy_cfg_writer_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_addr = '0, req_data = '0, hold_cycles = 8'd1;
  logic       req_ready, busy, done, ptest_clk, ptest_en, ptest_clr;
  logic [7:0] ptest_din;

  int checks = 0, fails = 0, writes_seen = 0, writes_sent = 0;
  logic [15:0] exp_q[$];
  logic [15:0] exp_item;
  logic [7:0]  phy_addr_lat = '0;

  phy_cfg_writer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .hold_cycles(hold_cycles),
    .busy(busy), .done(done), .ptest_clk(ptest_clk), .ptest_en(ptest_en),
    .ptest_clr(ptest_clr), .ptest_din(ptest_din)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural PHY register latch and scoreboard monitor (R4)
  always @(negedge ptest_clk) if (rst_n && ptest_en) phy_addr_lat <= ptest_din;
  always @(posedge ptest_clk) begin
    if (rst_n && !ptest_en) begin
      writes_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unrequested PHY write", {phy_addr_lat, ptest_din}, 0);
      end else begin
        exp_item = exp_q.pop_front();
        check({phy_addr_lat, ptest_din} == exp_item, "R4", "PHY addr/data pair",
              {phy_addr_lat, ptest_din}, exp_item);
      end
    end
  end

  task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                          input logic [7:0] hold, input bit inject,
                          input bit mid_hold, input bit chain_next,
                          input logic [7:0] na, input logic [7:0] nd);
    int h, bad_pins, bad_busy, bad_clr;
    logic xc, xe;
    logic [7:0] xd;
    @(negedge clk);
    req_addr = a; req_data = d; hold_cycles = hold; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back({a, d});
    writes_sent++;
    @(negedge clk);
    req_valid = 1'b0;
    h = (hold == 8'd0) ? 1 : int'(hold);
    bad_pins = 0; bad_busy = 0; bad_clr = 0;
    for (int j = 0; j < 5 * h; j++) begin
      case (j / h)
        0: begin xc = 1; xe = 0; xd = 8'h00; end
        1: begin xc = 1; xe = 1; xd = a; end
        2: begin xc = 0; xe = 1; xd = a; end
        3: begin xc = 0; xe = 0; xd = d; end
        default: begin xc = 1; xe = 0; xd = d; end
      endcase
      if (ptest_clk !== xc || ptest_en !== xe || ptest_din !== xd) bad_pins++;
      if (busy !== 1'b1 || done !== 1'b0 || req_ready !== 1'b0) bad_busy++;
      if (ptest_clr !== 1'b0) bad_clr++;
      if (inject && j == 2) begin req_valid = 1'b1; req_addr = 8'hEE; req_data = 8'h11; end
      if (inject && j == 3) req_valid = 1'b0;
      if (mid_hold && j == 1) hold_cycles = 8'd9;
      if (chain_next && j == 5 * h - 1) begin
        req_addr = na; req_data = nd; hold_cycles = 8'd2; req_valid = 1'b1;
      end
      @(negedge clk);
    end
    check(bad_pins == 0, "R3", "phase pin sequence mismatches", bad_pins, 0);
    check(bad_busy == 0, mid_hold ? "R6" : "R5", "busy window mismatches", bad_busy, 0);
    check(bad_clr == 0, "R7", "test clear high cycles", bad_clr, 0);
    check(done === 1'b1 && busy === 1'b0, "R8", "done/busy at end", {done, busy}, 2'b10);
    check(req_ready === 1'b1, "R8", "ready in done cycle", req_ready, 1);
    check(ptest_clk === 1'b1 && ptest_en === 1'b0, "R1", "rest pins after write",
          {ptest_clk, ptest_en}, 2'b10);
    if (!chain_next) begin
      @(negedge clk);
      check(done === 1'b0, "R8", "done width", done, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ptest_clk === 1 && ptest_en === 0 && ptest_clr === 0 && ptest_din === 8'h00,
          "R1", "pins in reset", {ptest_clk, ptest_en, ptest_clr, ptest_din}, 11'h400);
    check(busy === 0 && req_ready === 1 && done === 0, "R1", "handshake in reset",
          {busy, req_ready, done}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 0 && req_ready === 1, "R1", "idle after reset", {busy, req_ready}, 2'b01);

    do_write(8'h00, 8'hFF, 8'd1, 0, 0, 0, 8'h00, 8'h00);
    do_write(8'hA5, 8'h5A, 8'd3, 1, 0, 0, 8'h00, 8'h00);  // R2 foreign request mid-write
    do_write(8'hFF, 8'h00, 8'd0, 0, 0, 0, 8'h00, 8'h00);  // R5 zero hold acts as one
    do_write(8'h3C, 8'h81, 8'd5, 0, 1, 0, 8'h00, 8'h00);  // R6 hold changed mid-write
    do_write(8'h3C, 8'h7E, 8'd2, 0, 0, 1, 8'h42, 8'h24);  // R8 next request waits for done
    // The chained request is accepted in the done cycle above
    exp_q.push_back({8'h42, 8'h24});
    writes_sent++;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R8", "back-to-back accept in done cycle", busy, 1);
    while (busy) @(negedge clk);
    check(done === 1'b1, "R8", "chained write finished", done, 1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4", "pending expected writes", exp_q.size(), 0);
    check(writes_seen == writes_sent, "R2", "PHY writes observed", writes_seen, writes_sent);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule